// File: doc/BRIEF.md
# Credit-Based Logical Channel Link Multiplexer

This block lets several logical channels share one unidirectional, byte-wide physical link. Each channel has its own 32-bit word stream. The transmit half picks one channel at a time with a round-robin arbiter. It then sends the chosen word as four consecutive bytes. The channel number travels alongside the leading byte. The receive half rebuilds each word and places it in a private eight-entry queue for that channel. A downstream consumer drains those queues one word per cycle.

Flow control uses credits held at the sender. There is no handshake per transfer. The transmitter keeps a count of free receive slots for every channel and spends one credit per word it launches. Each time the consumer removes a word, the receiver sends back a dequeue notice that names the channel, and that channel regains one credit. A channel with no pending word, or with no credit left, is never scheduled. A lone busy channel therefore gets every byte slot of the link.

The top module carries both halves. Its link outputs and dequeue-notice outputs connect to a remote partner's inputs. In a loopback setup they connect to its own inputs.

Top module: `lcm_link_mux`

## Requirements
- R1: After reset all receive queues are empty, the link and the dequeue-notice output are idle, and every channel holds eight credits. With no dequeue, exactly eight words are accepted on a channel.
- R2: A granted word appears on the link output starting the cycle after the grant. It is sent as four bytes on consecutive cycles, least significant byte first. The first-byte flag and the channel index are valid with byte 0 only.
- R3: The receiver writes the rebuilt word into the queue named by the index of its first byte. The word is visible at that queue's head one cycle after byte 3 arrives, and each queue delivers its words in arrival order.
- R4: No channel ever has more than eight words in flight plus queued, so no word is ever sent toward a full queue.
- R5: A pop request on a non-empty queue removes the head word and raises the dequeue notice with that channel's index in the next cycle. A pop request on an empty queue changes nothing and raises no notice.
- R6: A dequeue notice adds one credit to its channel starting in the following cycle. A channel at zero credit is not granted in the same cycle that its notice arrives.
- R7: The arbiter grants only channels that have a word waiting and nonzero credit. It searches starting from the channel after the last one granted, and after reset it searches from channel 0.
- R8: Idle and credit-starved channels take no link slots. A single eligible channel receives back-to-back words, so the link stays busy on every cycle.
- R9: A source word is taken in the cycle its ready bit is high, and at most one ready bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NCH | A word is waiting on each channel |
| src_data | input | NCH*32 | Source words, channel c at bits [32c+31:32c] |
| src_ready | output | NCH | Word on that channel taken this cycle |
| lnk_o_valid | output | 1 | Outgoing link byte valid |
| lnk_o_first | output | 1 | Outgoing byte is byte 0 of a word |
| lnk_o_chan | output | IW | Channel index of the outgoing word |
| lnk_o_byte | output | 8 | Outgoing link byte |
| ret_i_valid | input | 1 | Dequeue notice from the remote receiver |
| ret_i_chan | input | IW | Channel of that notice |
| lnk_i_valid | input | 1 | Incoming link byte valid |
| lnk_i_first | input | 1 | Incoming byte is byte 0 of a word |
| lnk_i_chan | input | IW | Channel index of the incoming word |
| lnk_i_byte | input | 8 | Incoming link byte |
| pop_valid | input | 1 | Consumer removes one word |
| pop_chan | input | IW | Queue to pop |
| sink_nonempty | output | NCH | Queue holds at least one word |
| sink_data | output | NCH*32 | Head word of each queue |
| ret_o_valid | output | 1 | Dequeue notice to the remote transmitter |
| ret_o_chan | output | IW | Channel of that notice |

## Verification
All checks sample at the falling edge, after the rising edge that is due to produce the result. A grant is visible as a ready pulse in the cycle before the edge that takes the word. Bytes 0 through 3 follow on the next four falling edges, and the word reaches its queue head one edge after byte 3. A pop request shows its dequeue notice after exactly one edge. The returned credit makes the channel eligible one edge after that, and the bench checks that it is still refused during the notice cycle. Arbitration order is recorded from the first-byte flags in consecutive grants.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int BCW    = $clog2(BYTES);
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lcm_rr_arb.sv
module lcm_rr_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  // search begins at ptr and wraps around
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!gnt_vld && req[j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv && gnt_vld)
      ptr <= (int'(gnt_idx) == N-1) ? '0 : gnt_idx + 1'b1;
  end

  assert_grant_is_request_R7: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> req[gnt_idx]);
endmodule

// File: rtl/lcm_tx.sv
module lcm_tx
  import lcm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int IW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        src_valid,
  input  logic [NCH*WORD_W-1:0] src_data,
  output logic [NCH-1:0]        src_ready,
  input  logic                  ret_valid,
  input  logic [IW-1:0]         ret_chan,
  output logic                  lnk_valid,
  output logic                  lnk_first,
  output logic [IW-1:0]         lnk_chan,
  output byte_t                 lnk_byte
);
  logic [NCH-1:0][CW-1:0] credit;
  logic [NCH-1:0] elig, dec, inc;
  logic gnt_vld, slot_free, take;
  logic [IW-1:0] gnt_idx;
  logic [BCW-1:0] bcnt;
  logic [WORD_W-BYTE_W-1:0] shreg;
  word_t pick;

  always_comb begin
    for (int c = 0; c < NCH; c++) elig[c] = src_valid[c] && (credit[c] != '0);
  end

  lcm_rr_arb #(.N(NCH), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req(elig), .adv(take),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
  );

  assign slot_free = !lnk_valid || (int'(bcnt) == BYTES-1);
  assign take      = slot_free && gnt_vld;
  assign pick      = src_data[int'(gnt_idx)*WORD_W +: WORD_W];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      dec[c]       = take && (int'(gnt_idx) == c);
      inc[c]       = ret_valid && (int'(ret_chan) == c);
      src_ready[c] = dec[c];
    end
  end

  // per-channel free-slot counters, a returned credit counts from the next cycle
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) credit[c] <= CW'(DEPTH);
      else if (dec[c] && !inc[c]) credit[c] <= credit[c] - 1'b1;
      else if (inc[c] && !dec[c]) credit[c] <= credit[c] + 1'b1;
    end
  end

  // serializer: byte 0 with index, then remaining bytes low to high
  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_valid <= 1'b0;
      lnk_first <= 1'b0;
      lnk_chan  <= '0;
      lnk_byte  <= '0;
      bcnt      <= '0;
      shreg     <= '0;
    end else if (take) begin
      lnk_valid <= 1'b1;
      lnk_first <= 1'b1;
      lnk_chan  <= gnt_idx;
      lnk_byte  <= pick[BYTE_W-1:0];
      shreg     <= pick[WORD_W-1:BYTE_W];
      bcnt      <= '0;
    end else if (lnk_valid && int'(bcnt) != BYTES-1) begin
      lnk_first <= 1'b0;
      lnk_byte  <= shreg[BYTE_W-1:0];
      shreg     <= shreg >> BYTE_W;
      bcnt      <= bcnt + 1'b1;
    end else begin
      lnk_valid <= 1'b0;
      lnk_first <= 1'b0;
    end
  end

  assert_grant_has_credit_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> (credit[gnt_idx] != '0));
  assert_single_ready_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ready));
  assert_bytes_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
    (lnk_valid && int'(bcnt) != BYTES-1) |=> (lnk_valid && !lnk_first));

  for (genvar g = 0; g < NCH; g++) begin : g_cred_chk
    assert_credit_bound_R4: assert property (@(posedge clk) disable iff (rst)
      int'(credit[g]) <= DEPTH);
  end
endmodule

// File: rtl/lcm_rx_queue.sv
module lcm_rx_queue
  import lcm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  word_t wr_data,
  input  logic  rd_en,
  output logic  empty,
  output logic  full,
  output word_t head
);
  word_t mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (int'(cnt) == DEPTH);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (int'(wp) == DEPTH-1) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (int'(rp) == DEPTH-1) ? '0 : rp + 1'b1;
      if (wr_en && !rd_en) cnt <= cnt + 1'b1;
      else if (rd_en && !wr_en) cnt <= cnt - 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!full || rd_en));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/lcm_rx.sv
module lcm_rx
  import lcm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lnk_valid,
  input  logic                  lnk_first,
  input  logic [IW-1:0]         lnk_chan,
  input  byte_t                 lnk_byte,
  input  logic                  pop_valid,
  input  logic [IW-1:0]         pop_chan,
  output logic [NCH-1:0]        sink_nonempty,
  output logic [NCH*WORD_W-1:0] sink_data,
  output logic                  ret_valid,
  output logic [IW-1:0]         ret_chan
);
  logic [IW-1:0] cur_chan;
  logic [BCW-1:0] bcnt;
  logic [WORD_W-BYTE_W-1:0] asm_q;
  logic wr_fire, pop_ok;
  logic [NCH-1:0] q_empty, q_full, q_wr, q_rd;
  word_t wr_word;

  assign wr_fire = lnk_valid && !lnk_first && (int'(bcnt) == BYTES-1);
  assign wr_word = {lnk_byte, asm_q};
  assign pop_ok  = pop_valid && !q_empty[pop_chan];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_chan <= '0;
      bcnt     <= '0;
      asm_q    <= '0;
    end else if (lnk_valid) begin
      if (lnk_first) begin
        cur_chan <= lnk_chan;
        asm_q[BYTE_W-1:0] <= lnk_byte;
        bcnt <= BCW'(1);
      end else if (int'(bcnt) != BYTES-1) begin
        asm_q[int'(bcnt)*BYTE_W +: BYTE_W] <= lnk_byte;
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_q
    assign q_wr[g] = wr_fire && (int'(cur_chan) == g);
    assign q_rd[g] = pop_ok && (int'(pop_chan) == g);
    assign sink_nonempty[g] = !q_empty[g];
    lcm_rx_queue #(.DEPTH(DEPTH)) u_q (
      .clk(clk), .rst(rst), .wr_en(q_wr[g]), .wr_data(wr_word),
      .rd_en(q_rd[g]), .empty(q_empty[g]), .full(q_full[g]),
      .head(sink_data[g*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid <= 1'b0;
      ret_chan  <= '0;
    end else begin
      ret_valid <= pop_ok;
      ret_chan  <= pop_chan;
    end
  end

  assert_pop_notice_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && !q_empty[pop_chan]) |=> (ret_valid && ret_chan == $past(pop_chan)));
  assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && q_empty[pop_chan]) |=> !ret_valid);
  assert_write_has_room_R4: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> !q_full[cur_chan]);
endmodule

// File: rtl/lcm_link_mux.sv
module lcm_link_mux
  import lcm_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8,
  parameter int IW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        src_valid,
  input  logic [NCH*WORD_W-1:0] src_data,
  output logic [NCH-1:0]        src_ready,
  output logic                  lnk_o_valid,
  output logic                  lnk_o_first,
  output logic [IW-1:0]         lnk_o_chan,
  output logic [BYTE_W-1:0]     lnk_o_byte,
  input  logic                  ret_i_valid,
  input  logic [IW-1:0]         ret_i_chan,
  input  logic                  lnk_i_valid,
  input  logic                  lnk_i_first,
  input  logic [IW-1:0]         lnk_i_chan,
  input  logic [BYTE_W-1:0]     lnk_i_byte,
  input  logic                  pop_valid,
  input  logic [IW-1:0]         pop_chan,
  output logic [NCH-1:0]        sink_nonempty,
  output logic [NCH*WORD_W-1:0] sink_data,
  output logic                  ret_o_valid,
  output logic [IW-1:0]         ret_o_chan
);
  lcm_tx #(.NCH(NCH), .DEPTH(DEPTH), .IW(IW)) u_tx (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .ret_valid(ret_i_valid), .ret_chan(ret_i_chan),
    .lnk_valid(lnk_o_valid), .lnk_first(lnk_o_first),
    .lnk_chan(lnk_o_chan), .lnk_byte(lnk_o_byte)
  );

  lcm_rx #(.NCH(NCH), .DEPTH(DEPTH), .IW(IW)) u_rx (
    .clk(clk), .rst(rst),
    .lnk_valid(lnk_i_valid), .lnk_first(lnk_i_first),
    .lnk_chan(lnk_i_chan), .lnk_byte(lnk_i_byte),
    .pop_valid(pop_valid), .pop_chan(pop_chan),
    .sink_nonempty(sink_nonempty), .sink_data(sink_data),
    .ret_valid(ret_o_valid), .ret_chan(ret_o_chan)
  );
endmodule

// File: tb/test_lcm_link_mux.sv
`timescale 1ns/1ps
module test_lcm_link_mux;
  localparam int NCH = 4;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] src_valid = '0;
  logic [NCH*32-1:0] src_data = '0;
  logic [NCH-1:0] src_ready;
  logic lnk_valid, lnk_first;
  logic [IW-1:0] lnk_chan;
  logic [7:0] lnk_byte;
  logic ret_valid;
  logic [IW-1:0] ret_chan;
  logic pop_valid = 1'b0;
  logic [IW-1:0] pop_chan = '0;
  logic [NCH-1:0] sink_nonempty;
  logic [NCH*32-1:0] sink_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcm_link_mux #(.NCH(NCH), .DEPTH(8)) i_lcm_link_mux (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .lnk_o_valid(lnk_valid), .lnk_o_first(lnk_first),
    .lnk_o_chan(lnk_chan), .lnk_o_byte(lnk_byte),
    .ret_i_valid(ret_valid), .ret_i_chan(ret_chan),
    .lnk_i_valid(lnk_valid), .lnk_i_first(lnk_first),
    .lnk_i_chan(lnk_chan), .lnk_i_byte(lnk_byte),
    .pop_valid(pop_valid), .pop_chan(pop_chan),
    .sink_nonempty(sink_nonempty), .sink_data(sink_data),
    .ret_o_valid(ret_valid), .ret_o_chan(ret_chan)
  );

  // {chan[1:0], word[31:0]}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 32'h1122_3344}, {2'd3, 32'hA5A5_0F0F}, {2'd1, 32'hDEAD_BEEF},
    {2'd2, 32'h0000_0001}, {2'd0, 32'hFFFF_FFFF}, {2'd2, 32'h8000_0000},
    {2'd1, 32'h0123_4567}, {2'd3, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_valid = '0; pop_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input int ch, input logic [31:0] w);
    @(negedge clk);
    src_valid[ch] = 1'b1;
    src_data[ch*32 +: 32] = w;
    #1;
    while (!src_ready[ch]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    src_valid[ch] = 1'b0;
  endtask

  task automatic pop(input int ch);
    @(negedge clk);
    pop_valid = 1'b1; pop_chan = IW'(ch);
    @(negedge clk);
    pop_valid = 1'b0;
  endtask

  // records channel order of the next n words seen on the link
  task automatic watch_order(input int n, output int seq [8]);
    int got = 0;
    for (int k = 0; k < 8; k++) seq[k] = -1;
    for (int cyc = 0; cyc < 80 && got < n; cyc++) begin
      @(negedge clk);
      if (lnk_valid && lnk_first) begin seq[got] = int'(lnk_chan); got++; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seq [8];
    int acc, hi, run, maxrun;

    do_reset();
    // R1: idle state after reset
    check(sink_nonempty == '0, "R1", "queues empty", 32'(sink_nonempty), 0);
    check(!lnk_valid, "R1", "link idle", 32'(lnk_valid), 0);
    check(!ret_valid, "R1", "no notice", 32'(ret_valid), 0);

    // vector table: one word per step, link bytes, queue head, dequeue notice
    for (int i = 0; i < 8; i++) begin
      int ch;
      logic [31:0] w;
      ch = int'(VEC[i][33:32]);
      w  = VEC[i][31:0];
      @(negedge clk);
      src_valid[ch] = 1'b1;
      src_data[ch*32 +: 32] = w;
      #1;
      check(src_ready[ch], "R9", "ready on idle link", 32'(src_ready), 32'(1 << ch));
      for (int b = 0; b < 4; b++) begin
        @(negedge clk);
        if (b == 0) src_valid[ch] = 1'b0;
        check(lnk_valid && lnk_first == (b == 0) && lnk_byte == w[b*8 +: 8] &&
              (b != 0 || int'(lnk_chan) == ch), "R2", "link byte",
              {22'd0, lnk_valid, lnk_first, lnk_byte}, {22'd0, 1'b1, b == 0, w[b*8 +: 8]});
      end
      @(negedge clk);
      check(sink_nonempty == NCH'(1 << ch) && sink_data[ch*32 +: 32] == w, "R3",
            "queue head", sink_data[ch*32 +: 32], w);
      pop_valid = 1'b1; pop_chan = IW'(ch);
      @(negedge clk);
      pop_valid = 1'b0;
      check(ret_valid && int'(ret_chan) == ch && sink_nonempty == '0, "R5",
            "dequeue notice", {30'd0, ret_chan}, 32'(ch));
    end

    // R3: arrival order kept within one queue
    push(2, 32'hAAAA_0001);
    push(2, 32'hAAAA_0002);
    push(2, 32'hAAAA_0003);
    repeat (8) @(negedge clk);
    for (int k = 1; k <= 3; k++) begin
      check(sink_data[2*32 +: 32] == 32'hAAAA_0000 + 32'(k), "R3", "fifo order",
            sink_data[2*32 +: 32], 32'hAAAA_0000 + 32'(k));
      pop(2);
    end

    // R5: popping an empty queue does nothing
    @(negedge clk);
    pop_valid = 1'b1; pop_chan = 2'd0;
    @(negedge clk);
    pop_valid = 1'b0;
    check(!ret_valid && sink_nonempty == '0, "R5", "empty pop ignored",
          {31'd0, ret_valid}, 0);

    // R1 R4 R8: credit exhaustion with one busy channel
    do_reset();
    src_valid[1] = 1'b1;
    src_data[1*32 +: 32] = 32'h5555_AAAA;
    acc = 0; hi = 0; run = 0; maxrun = 0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      #1;
      if (src_ready[1]) acc++;
      if (lnk_valid) begin hi++; run++; if (run > maxrun) maxrun = run; end
      else run = 0;
      @(negedge clk);
    end
    check(acc == 8, "R1", "initial credit", 32'(acc), 8);
    check(acc == 8 && sink_nonempty[1], "R4", "stop at full queue", 32'(acc), 8);
    check(hi == 32 && maxrun == 32, "R8", "back to back link use", 32'(maxrun), 32);

    // R6: credit return takes effect one cycle after the notice
    pop_valid = 1'b1; pop_chan = 2'd1;
    #1;
    check(!src_ready[1], "R6", "zero credit refused", 32'(src_ready), 0);
    @(negedge clk);
    pop_valid = 1'b0;
    #1;
    check(ret_valid && !src_ready[1], "R6", "notice cycle still refused",
          {30'd0, ret_valid, src_ready[1]}, 32'b10);
    @(negedge clk); #1;
    check(src_ready[1], "R6", "credit restored", 32'(src_ready), 32'b0010);
    @(posedge clk); #1;
    src_valid[1] = 1'b0;

    // R7: rotation from reset with all channels busy
    do_reset();
    for (int c = 0; c < NCH; c++) src_data[c*32 +: 32] = 32'hC0DE_0000 + 32'(c);
    src_valid = '1;
    watch_order(8, seq);
    src_valid = '0;
    for (int k = 0; k < 8; k++)
      check(seq[k] == k % 4, "R7", "rotation order", 32'(seq[k]), 32'(k % 4));

    // R8: idle channels are skipped
    do_reset();
    src_valid = 4'b0101;
    watch_order(4, seq);
    src_valid = '0;
    for (int k = 0; k < 4; k++)
      check(seq[k] == ((k % 2) * 2), "R8", "skip idle", 32'(seq[k]), 32'((k % 2) * 2));

    // R7: search resumes after the last granted channel
    do_reset();
    push(2, 32'h0000_0222);
    @(negedge clk);
    src_valid = 4'b1110;
    watch_order(3, seq);
    src_valid = '0;
    check(seq[0] == 3, "R7", "after last grant", 32'(seq[0]), 3);
    check(seq[1] == 1, "R7", "wrap skips idle 0", 32'(seq[1]), 1);
    check(seq[2] == 2, "R7", "then 2", 32'(seq[2]), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule